// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between one bus master and one memory or peripheral slave. Two address windows, each 32 MB long, are treated as bit aliases. Every 32-bit word in an alias window stands for one bit of a 1 MB target region. Window 0 at 0x22000000 maps onto the region at 0x20000000. Window 1 at 0x42000000 maps onto the region at 0x40000000. The target byte address is the region base ORed with bits [24:5] of the alias address. The bit number is taken from the alias address starting at bit 2.

An alias read fetches the target at the requested size and returns the selected bit as 0 or 1. An alias write turns into a locked read-modify-write: the target is read at the requested size, then written back at the same size with only the selected bit changed. Any access outside both windows goes to the slave unchanged. The bridge handles one request at a time and gives exactly one response for each request.

All four channels use valid/ready. On each channel the sender holds valid and its payload steady until ready is seen at a clock edge. The master's request is taken only while the bridge is idle. A response waits for `m_rsp_ready` for as long as the master holds it low. The slave may stall both its request and its response channel for any number of cycles. Size codes are 0 for byte, 1 for halfword and 2 for word; code 3 is handled as word. Data is right-aligned and little-endian: the byte at address+i sits in data bits [8i+7:8i].

Top module: `bitband_bridge`

## Requirements
- R1: A master address whose bits [31:25] match 0x22000000 or 0x42000000 is an alias access to target region 0x20000000 or 0x40000000. All other addresses, including 0x21FFFFFC and 0x44000000, are passed through.
- R2: For an alias access the slave address is the region base ORed with alias address bits [24:5]. This address is forced even for halfword accesses and forced to a multiple of 4 for word accesses. The slave size equals the master size.
- R3: The selected bit is alias address bits [4:2] for a byte, [5:2] for a halfword and [6:2] for a word. Bit n is counted in the little-endian value the slave returns.
- R4: An alias read responds with 1 in data bit 0 when the selected bit is set and 0 when it is clear. All other response bits are 0.
- R5: An alias write uses only bit 0 of the write data: 1 sets the selected bit and 0 clears it. All other bits of the target keep their values.
- R6: An alias write makes two slave transfers to the same address at the same size: first a read, then a write. `s_req_lock` is high from the start of the read request until the write response is accepted. Alias reads and pass-through accesses never raise the lock.
- R7: A pass-through access reaches the slave with its own address, size, direction and write data. A read returns the slave data unchanged. A write responds with 0.
- R8: `m_req_ready` is high only while idle. Each accepted request produces exactly one response. A response, and each slave request, is held steady until its ready is seen.
- R9: After reset the bridge is idle: `m_req_ready` is 1, and `m_rsp_valid`, `s_req_valid` and `s_req_lock` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Bridge ready to accept a request (idle) |
| m_req_addr | input | 32 | Master byte address |
| m_req_write | input | 1 | 1 = write, 0 = read |
| m_req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| m_req_wdata | input | 32 | Master write data, right-aligned |
| m_rsp_valid | output | 1 | Response valid |
| m_rsp_ready | input | 1 | Master accepts the response |
| m_rsp_rdata | output | 32 | Response data |
| s_req_valid | output | 1 | Slave request valid |
| s_req_ready | input | 1 | Slave accepts the request |
| s_req_addr | output | 32 | Slave byte address |
| s_req_write | output | 1 | Slave direction, 1 = write |
| s_req_size | output | 2 | Slave access size |
| s_req_wdata | output | 32 | Slave write data |
| s_req_lock | output | 1 | Hold the slave for a read-modify-write |
| s_rsp_valid | input | 1 | Slave response valid |
| s_rsp_ready | output | 1 | Bridge accepts the slave response |
| s_rsp_rdata | input | 32 | Slave read data |

## Verification
A wrong sequencer state shows up at the slave port within a cycle or two. Typical signs are a write phase that arrives without the read before it, a lock that drops between the two phases, or a request at the wrong address or size. The bench checks every slave request as it is accepted. A wrong bit index or mask does not show up at once. It appears either as a wrong 0/1 alias response or as corrupted neighbouring bits, which the next pass-through read of that word reveals. Back-pressure is applied on all four channels, so a bridge that drops or repeats a response leaves the scoreboard out of step at the next response.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bb_size_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_WR_WAIT = 3'd4,
    ST_RESP    = 3'd5
  } bb_state_e;

  // one alias word per target bit: 8 bits per byte, 4 bytes per alias word
  localparam int unsigned ALIAS_BYTE_SHIFT = 5;
  localparam int unsigned ALIAS_BIT_LSB    = 2;
  localparam int unsigned BIT_IDX_W        = 5;
endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_WIN   = 2,
  parameter int unsigned SPAN_LOG2 = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] TGT_BASES   = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  output logic                 hit,
  output logic [ADDR_W-1:0]    tgt_addr,
  output logic [BIT_IDX_W-1:0] bit_idx
);
  localparam logic [ADDR_W-1:0] SPAN_MASK =
    ADDR_W'((64'd1 << SPAN_LOG2) - 64'd1);

  logic [NUM_WIN-1:0]             match;
  logic [NUM_WIN-1:0][ADDR_W-1:0] raw_tgt;
  logic [ADDR_W-1:0]              sel_tgt;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] AB = ALIAS_BASES[w*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] TB = TGT_BASES[w*ADDR_W +: ADDR_W];
    assign match[w]   = (addr[ADDR_W-1:SPAN_LOG2] == AB[ADDR_W-1:SPAN_LOG2]);
    assign raw_tgt[w] = TB | ((addr & SPAN_MASK) >> ALIAS_BYTE_SHIFT);
  end

  always_comb begin
    sel_tgt = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (match[w]) sel_tgt = raw_tgt[w];
    end
  end

  assign hit = |match;

  always_comb begin
    unique case (bb_size_e'(size))
      SZ_BYTE: begin
        tgt_addr = sel_tgt;
        bit_idx  = {2'b00, addr[ALIAS_BIT_LSB +: 3]};
      end
      SZ_HALF: begin
        tgt_addr = {sel_tgt[ADDR_W-1:1], 1'b0};
        bit_idx  = {1'b0, addr[ALIAS_BIT_LSB +: 4]};
      end
      default: begin
        tgt_addr = {sel_tgt[ADDR_W-1:2], 2'b00};
        bit_idx  = addr[ALIAS_BIT_LSB +: 5];
      end
    endcase
  end

  logic unused_lo;
  assign unused_lo = ^addr[ALIAS_BIT_LSB-1:0];
endmodule

// File: rtl/bb_bit_mask.sv
module bb_bit_mask
  import bb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]    rd_data,
  input  logic [BIT_IDX_W-1:0] bit_idx,
  input  logic                 set_val,
  output logic                 bit_val,
  output logic [DATA_W-1:0]    wr_data
);
  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign mask[i]    = (bit_idx == BIT_IDX_W'(i));
    assign wr_data[i] = mask[i] ? set_val : rd_data[i];
  end

  assign bit_val = |(rd_data & mask);
endmodule

// File: rtl/bb_rmw_seq.sv
module bb_rmw_seq
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 m_req_valid,
  output logic                 m_req_ready,
  input  logic [ADDR_W-1:0]    m_req_addr,
  input  logic                 m_req_write,
  input  logic [1:0]           m_req_size,
  input  logic [DATA_W-1:0]    m_req_wdata,
  input  logic                 dec_hit,
  input  logic [ADDR_W-1:0]    dec_addr,
  input  logic [BIT_IDX_W-1:0] dec_bit,
  output logic                 m_rsp_valid,
  input  logic                 m_rsp_ready,
  output logic [DATA_W-1:0]    m_rsp_rdata,
  output logic                 s_req_valid,
  input  logic                 s_req_ready,
  output logic [ADDR_W-1:0]    s_req_addr,
  output logic                 s_req_write,
  output logic [1:0]           s_req_size,
  output logic [DATA_W-1:0]    s_req_wdata,
  output logic                 s_req_lock,
  input  logic                 s_rsp_valid,
  output logic                 s_rsp_ready,
  input  logic [DATA_W-1:0]    s_rsp_rdata,
  output logic [DATA_W-1:0]    rd_hold,
  output logic [BIT_IDX_W-1:0] bit_sel,
  output logic                 set_val,
  input  logic                 bit_val,
  input  logic [DATA_W-1:0]    mod_data
);
  bb_state_e            state_q, state_d;
  logic                 alias_q, write_q;
  logic [1:0]           size_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q, rdata_q;
  logic [BIT_IDX_W-1:0] bit_q;
  logic                 accept, rmw_op;

  assign accept = m_req_valid && (state_q == ST_IDLE);
  assign rmw_op = alias_q && write_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (m_req_valid)
                    state_d = (m_req_write && !dec_hit) ? ST_WR_REQ : ST_RD_REQ;
      ST_RD_REQ:  if (s_req_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (s_rsp_valid) state_d = rmw_op ? ST_WR_REQ : ST_RESP;
      ST_WR_REQ:  if (s_req_ready) state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (s_rsp_valid) state_d = ST_RESP;
      ST_RESP:    if (m_rsp_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      alias_q <= 1'b0;
      write_q <= 1'b0;
      size_q  <= 2'b00;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        alias_q <= dec_hit;
        write_q <= m_req_write;
        size_q  <= m_req_size;
        addr_q  <= dec_hit ? dec_addr : m_req_addr;
        wdata_q <= m_req_wdata;
        bit_q   <= dec_bit;
      end
      if (state_q == ST_RD_WAIT && s_rsp_valid) rdata_q <= s_rsp_rdata;
    end
  end

  assign m_req_ready = (state_q == ST_IDLE);
  assign s_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign s_req_write = (state_q == ST_WR_REQ);
  assign s_req_addr  = addr_q;
  assign s_req_size  = size_q;
  assign s_req_wdata = alias_q ? mod_data : wdata_q;
  assign s_rsp_ready = (state_q == ST_RD_WAIT) || (state_q == ST_WR_WAIT);
  assign s_req_lock  = rmw_op && (state_q inside {ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT});
  assign m_rsp_valid = (state_q == ST_RESP);
  assign m_rsp_rdata = write_q ? '0 : (alias_q ? DATA_W'(bit_val) : rdata_q);

  assign rd_hold = rdata_q;
  assign bit_sel = bit_q;
  assign set_val = wdata_q[0];

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_valid && !m_rsp_ready |=> m_rsp_valid && $stable(m_rsp_rdata));
  // R8
  sreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_valid && !s_req_ready |=> s_req_valid && $stable(s_req_addr) && $stable(s_req_write) && $stable(s_req_size));
  // R6
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_req_lock) |-> m_rsp_valid);
  // R6
  lock_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_valid && s_req_write && s_req_lock |-> $past(s_req_lock));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_ready |-> !m_rsp_valid && !s_req_valid && !s_req_lock);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WIN   = 2,
  parameter int unsigned SPAN_LOG2 = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] TGT_BASES   = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_req_valid,
  output logic              m_req_ready,
  input  logic [ADDR_W-1:0] m_req_addr,
  input  logic              m_req_write,
  input  logic [1:0]        m_req_size,
  input  logic [DATA_W-1:0] m_req_wdata,
  output logic              m_rsp_valid,
  input  logic              m_rsp_ready,
  output logic [DATA_W-1:0] m_rsp_rdata,
  output logic              s_req_valid,
  input  logic              s_req_ready,
  output logic [ADDR_W-1:0] s_req_addr,
  output logic              s_req_write,
  output logic [1:0]        s_req_size,
  output logic [DATA_W-1:0] s_req_wdata,
  output logic              s_req_lock,
  input  logic              s_rsp_valid,
  output logic              s_rsp_ready,
  input  logic [DATA_W-1:0] s_rsp_rdata
);
  logic                 dec_hit;
  logic [ADDR_W-1:0]    dec_addr;
  logic [BIT_IDX_W-1:0] dec_bit;
  logic [DATA_W-1:0]    rd_hold, mod_data;
  logic [BIT_IDX_W-1:0] bit_sel;
  logic                 set_val, bit_val;

  bb_window_decode #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .SPAN_LOG2(SPAN_LOG2),
    .ALIAS_BASES(ALIAS_BASES), .TGT_BASES(TGT_BASES)
  ) u_decode (
    .addr(m_req_addr), .size(m_req_size),
    .hit(dec_hit), .tgt_addr(dec_addr), .bit_idx(dec_bit)
  );

  bb_bit_mask #(.DATA_W(DATA_W)) u_mask (
    .rd_data(rd_hold), .bit_idx(bit_sel), .set_val(set_val),
    .bit_val(bit_val), .wr_data(mod_data)
  );

  bb_rmw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
    .m_req_addr(m_req_addr), .m_req_write(m_req_write),
    .m_req_size(m_req_size), .m_req_wdata(m_req_wdata),
    .dec_hit(dec_hit), .dec_addr(dec_addr), .dec_bit(dec_bit),
    .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready), .m_rsp_rdata(m_rsp_rdata),
    .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_addr(s_req_addr),
    .s_req_write(s_req_write), .s_req_size(s_req_size), .s_req_wdata(s_req_wdata),
    .s_req_lock(s_req_lock),
    .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready), .s_rsp_rdata(s_rsp_rdata),
    .rd_hold(rd_hold), .bit_sel(bit_sel), .set_val(set_val),
    .bit_val(bit_val), .mod_data(mod_data)
  );
endmodule

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        m_req_valid = 0, m_req_write = 0, m_rsp_ready = 0;
  logic [31:0] m_req_addr = 0, m_req_wdata = 0;
  logic [1:0]  m_req_size = 0;
  logic        m_req_ready, m_rsp_valid;
  logic [31:0] m_rsp_rdata;
  logic        s_req_valid, s_req_write, s_req_lock, s_rsp_ready;
  logic [31:0] s_req_addr, s_req_wdata;
  logic [1:0]  s_req_size;
  logic        s_req_ready = 0, s_rsp_valid = 0;
  logic [31:0] s_rsp_rdata = 0;

  bitband_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_addr(m_req_addr),
    .m_req_write(m_req_write), .m_req_size(m_req_size), .m_req_wdata(m_req_wdata),
    .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready), .m_rsp_rdata(m_rsp_rdata),
    .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_addr(s_req_addr),
    .s_req_write(s_req_write), .s_req_size(s_req_size), .s_req_wdata(s_req_wdata),
    .s_req_lock(s_req_lock), .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready),
    .s_rsp_rdata(s_rsp_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  logic [7:0] smem [logic [31:0]];
  logic [7:0] rmem [logic [31:0]];

  logic [31:0] exp_s_addr;
  logic [1:0]  exp_s_size;
  logic        exp_lock;
  string       exp_tag;
  int          n_alias_wr = 0;
  int          n_locked_wr = 0;
  logic        last_rd_locked = 0;
  logic [31:0] last_rd_addr = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sbyte(input logic [31:0] a);
    return smem.exists(a) ? smem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] rbyte(input logic [31:0] a);
    return rmem.exists(a) ? rmem[a] : 8'h00;
  endfunction

  // slave model: random-ish ready and latency
  int          sl_cyc = 0;
  int          sl_dly = 0;
  logic        sl_busy = 0, rsp_fire = 0;
  logic [31:0] sl_rd = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_fire) begin
        s_rsp_valid = 0;
        rsp_fire = 0;
        sl_busy = 0;
      end
      if (sl_busy && !s_rsp_valid) begin
        if (sl_dly == 0) begin
          s_rsp_valid = 1;
          s_rsp_rdata = sl_rd;
        end else sl_dly--;
      end
      if (s_rsp_valid && s_rsp_ready) rsp_fire = 1;
      sl_cyc++;
      s_req_ready = !sl_busy && (sl_cyc % 3 != 1);
      if (s_req_valid && s_req_ready) begin
        // R2 R6 R7: address, size and lock of each slave request
        chk(s_req_addr, exp_s_addr, {exp_tag, " slave addr"});
        chk({30'd0, s_req_size}, {30'd0, exp_s_size}, {exp_tag, " slave size"});
        chk({31'd0, s_req_lock}, {31'd0, exp_lock}, {exp_tag, " slave lock"});
        if (s_req_write) begin
          if (s_req_lock) begin
            n_locked_wr++;
            chk({31'd0, last_rd_locked}, 32'd1, "R6 locked read precedes locked write");
            chk(last_rd_addr, s_req_addr, "R6 write to same address as read");
          end
          for (int i = 0; i < (1 << s_req_size); i++)
            smem[s_req_addr + i] = s_req_wdata[8*i +: 8];
          sl_rd = 0;
          last_rd_locked = 0;
        end else begin
          sl_rd = 0;
          for (int i = 0; i < (1 << s_req_size); i++)
            sl_rd[8*i +: 8] = sbyte(s_req_addr + i);
          last_rd_locked = s_req_lock;
          last_rd_addr = s_req_addr;
        end
        sl_busy = 1;
        sl_dly = sl_cyc % 4;
      end
    end
  end

  // monitor: pops scoreboard on each master response
  int m_cyc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      m_cyc++;
      m_rsp_ready = (m_cyc % 5 != 2);
      if (m_rsp_valid && m_rsp_ready) begin
        if (sb_q.size() == 0) begin
          chk(32'd1, 32'd0, "R8 unexpected extra response");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(m_rsp_rdata, e.exp, e.tag);
        end
      end
    end
  end

  task automatic do_op(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [31:0] exp_rd,
                       input logic [31:0] s_addr, input logic lk, input string tag);
    exp_t e;
    @(negedge clk);
    exp_s_addr = s_addr;
    exp_s_size = sz;
    exp_lock   = lk;
    exp_tag    = tag;
    e.exp = exp_rd;
    e.tag = tag;
    sb_q.push_back(e);
    m_req_valid = 1;
    m_req_addr  = a;
    m_req_write = wr;
    m_req_size  = sz;
    m_req_wdata = wd;
    while (!m_req_ready) @(negedge clk);
    @(negedge clk);
    m_req_valid = 0;
    // R8: no new request accepted while one is in flight
    if (sb_q.size() != 0) chk({31'd0, m_req_ready}, 32'd0, "R8 ready low while busy");
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic pt_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
    for (int i = 0; i < (1 << sz); i++) rmem[a + i] = wd[8*i +: 8];
    do_op(a, 1'b1, sz, wd, 32'd0, a, 1'b0, "R7 passthrough write");
  endtask

  task automatic pt_read(input logic [31:0] a, input logic [1:0] sz, input string tag);
    logic [31:0] v;
    v = 0;
    for (int i = 0; i < (1 << sz); i++) v[8*i +: 8] = rbyte(a + i);
    do_op(a, 1'b0, sz, 32'd0, v, a, 1'b0, tag);
  endtask

  function automatic logic [31:0] alias_of(input int win, input logic [31:0] b, input int bitn);
    logic [31:0] tb, ab;
    tb = (win == 0) ? 32'h2000_0000 : 32'h4000_0000;
    ab = (win == 0) ? 32'h2200_0000 : 32'h4200_0000;
    return ab + (((b - tb) * 8 + 32'(bitn)) * 4);
  endfunction

  task automatic al_read(input int win, input logic [31:0] b, input int bitn,
                         input logic [1:0] sz, input string tag);
    logic [31:0] sa, ex;
    sa = b & ~((32'd1 << sz) - 1);
    ex = {31'd0, rbyte(b)[bitn]};
    do_op(alias_of(win, b, bitn), 1'b0, sz, 32'd0, ex, sa, 1'b0, tag);
  endtask

  task automatic al_write(input int win, input logic [31:0] b, input int bitn,
                          input logic [1:0] sz, input logic [31:0] wd, input string tag);
    logic [31:0] sa;
    logic [7:0]  v;
    sa = b & ~((32'd1 << sz) - 1);
    v = rbyte(b);
    v[bitn] = wd[0];
    rmem[b] = v;
    n_alias_wr++;
    do_op(alias_of(win, b, bitn), 1'b1, sz, wd, 32'd0, sa, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({31'd0, m_req_ready}, 32'd1, "R9 reset m_req_ready");
    chk({31'd0, m_rsp_valid}, 32'd0, "R9 reset m_rsp_valid");
    chk({31'd0, s_req_valid}, 32'd0, "R9 reset s_req_valid");
    chk({31'd0, s_req_lock},  32'd0, "R9 reset s_req_lock");
    rst_n = 1;

    // R7 pass-through, full word and halfword
    pt_write(32'h2000_0100, 2'd2, 32'hA5A5_0F0F);
    pt_read (32'h2000_0100, 2'd2, "R7 passthrough word read");
    pt_write(32'h3000_0010, 2'd2, 32'h1234_5678);
    pt_read (32'h3000_0010, 2'd1, "R7 passthrough half read");
    pt_read (32'h3000_0013, 2'd0, "R7 passthrough byte read");

    // R3 R4 alias reads at every size, window 0 (R1)
    al_read(0, 32'h2000_0100, 0, 2'd2, "R4 alias word read bit set");
    al_read(0, 32'h2000_0100, 4, 2'd2, "R4 alias word read bit clear");
    al_read(0, 32'h2000_0101, 3, 2'd1, "R3 alias half read odd byte");
    al_read(0, 32'h2000_0102, 5, 2'd0, "R3 alias byte read");
    al_read(0, 32'h2000_0103, 6, 2'd2, "R2 alias word read aligned");
    al_read(0, 32'h2000_0103, 7, 2'd1, "R2 alias half read forced even");

    // R5 alias writes: only wdata bit 0 counts
    al_write(0, 32'h2000_0101, 3, 2'd1, 32'hFFFF_FFFE, "R5 alias half clear");
    pt_read (32'h2000_0100, 2'd2, "R5 neighbours kept after clear");
    al_write(0, 32'h2000_0103, 6, 2'd0, 32'h0000_0001, "R5 alias byte set");
    al_write(0, 32'h2000_0102, 0, 2'd2, 32'h0000_0003, "R5 alias word set");
    pt_read (32'h2000_0100, 2'd2, "R5 word after sets");
    al_read(0, 32'h2000_0103, 6, 2'd0, "R4 alias read after set");

    // window 1 (R1)
    pt_write(32'h4000_0040, 2'd2, 32'h0000_0000);
    al_write(1, 32'h4000_0042, 7, 2'd2, 32'h0000_0001, "R1 window1 alias set");
    al_read (1, 32'h4000_0042, 7, 2'd1, "R1 window1 alias read");
    pt_read (32'h4000_0040, 2'd2, "R5 window1 word after set");

    // top of window 1 and window edges (R1 R2)
    pt_write(32'h400F_FFFC, 2'd2, 32'h8000_0000);
    al_read (1, 32'h400F_FFFF, 7, 2'd2, "R2 top alias word of window1");
    pt_write(32'h4400_0000, 2'd2, 32'hDEAD_BEEF);
    pt_read (32'h4400_0000, 2'd2, "R1 address past window1 passes");
    pt_read (32'h21FF_FFFC, 2'd2, "R1 address below window0 passes");

    // R6 every alias write used exactly one locked write
    chk(32'(n_locked_wr), 32'(n_alias_wr), "R6 locked RMW count");

    repeat (5) @(negedge clk);
    chk(32'(sb_q.size()), 32'd0, "R8 scoreboard drained");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule